// File: doc/BRIEF.md
# LED Driver Serial Command Sequencer

This block feeds a constant-current LED driver over a one-way, three-wire serial link: a shift clock `sck`, a data line `sin` and a control line `trans`. Software or a neighbouring block loads one brightness word per channel through a valid/ready write port. A single-cycle `start` strobe then launches a frame. A frame sends each channel's word as a data-shift command and then issues one latch command, which makes the driver move the shifted words to its outputs. When the frame is complete, `done` pulses for one system clock.

A data-shift command uses clock mode 0: `sck` idles low and the driver samples `sin` on each rising edge. `trans` stays low for the whole word and goes high for one half-period after the word's last bit. The latch command is not a select edge. `trans` first rests low with `sck` low for one half-period. `trans` then goes high, three full clock pulses are sent while it stays high, and finally `trans` and `sck` both return low. Both commands drive the same `sck` wire, and the sequencer runs them strictly one after the other.

Top module: `led_cmd_seq`

## Requirements
- R1: After reset, `sck`, `sin`, `trans`, `done` and `busy` are low and `wr_ready` is high.
- R2: A write with `wr_valid` and `wr_ready` both high stores `wr_data` as the word of channel `wr_addr`. `wr_ready` is low while a frame runs, so a write offered during a frame leaves that frame and later frames unchanged until the word is written again.
- R3: Each data-shift command sends exactly WORD_W (16) bits, most significant bit first, on rising `sck` edges. `sin` never changes while `sck` is high. `trans` is low at every one of the word's rising edges.
- R4: A frame sends the words in channel order 0, 1, …, CHANNELS-1, one command per channel.
- R5: After the last word, one latch command follows. It produces exactly 3 rising `sck` edges while `trans` is high. No other rising edge occurs while `trans` is high. It ends with `sck` and `trans` low.
- R6: Every high phase of `sck` lasts HALF_DIV system clocks, so the `sck` period is 2·HALF_DIV clocks. The minimum is HALF_DIV = 1.
- R7: `done` is high for exactly one clock per frame. Counting the clock that samples `start` as the first, `done` rises (2·WORD_W+1)·HALF_DIV·CHANNELS + 9·HALF_DIV + 1 clocks later.
- R8: A `start` pulse during a frame is ignored. No second frame, extra `sck` pulse or extra `done` follows.
- R9: `busy` is high from the clock after an accepted `start` until the frame finishes. While `busy` is low, `sck` and `trans` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Brightness write request |
| wr_ready | output | 1 | Write accepted this cycle when high |
| wr_addr | input | AW | Channel index of the write |
| wr_data | input | WORD_W | Brightness word |
| start | input | 1 | Launch one frame (ignored while busy) |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock pulse at frame end |
| sck | output | 1 | Serial shift clock to the driver |
| sin | output | 1 | Serial data to the driver |
| trans | output | 1 | Command control line to the driver |

## Verification
Frames are run with several word patterns. All-ones and all-zero words show whether `sin` is stuck or inverted. A pattern with a single set bit at each end exposes bit-order reversal. Distinct ascending nibble words per channel catch channel reordering and off-by-one channel indexing. A frame disturbed by a mid-frame `start` and a blocked write separates a correct idle guard from one that restarts or accepts data. Latch pulses are counted as rising edges seen while `trans` is high, which tells a correct latch apart from one with a missing or extra pulse, and also catches words sent with the wrong `trans` level.

// File: rtl/led_cmd_seq.sv
module led_cmd_seq #(
  parameter int CHANNELS = 4,
  parameter int WORD_W   = 16,
  parameter int HALF_DIV = 2,
  localparam int AW = (CHANNELS > 1) ? $clog2(CHANNELS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              sck,
  output logic              sin,
  output logic              trans
);

  localparam int HW        = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int SW        = $clog2(2 * WORD_W);
  localparam int BW        = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int WORD_LAST = 2 * WORD_W - 1;
  localparam int LATCH_LAST = 6;

  typedef enum logic [2:0] {
    S_IDLE, S_SHIFT, S_GAP, S_PRE, S_LATCH, S_POST, S_DONE
  } state_t;

  state_t            state;
  logic [HW-1:0]     hcnt;
  logic [SW-1:0]     step;
  logic [AW-1:0]     chan;
  logic [WORD_W-1:0] mem [CHANNELS];
  logic [BW-1:0]     bit_idx;
  logic              half_end;

  assign half_end = (hcnt == HW'(HALF_DIV - 1));
  assign busy     = (state != S_IDLE);
  assign wr_ready = ~busy;
  assign bit_idx  = BW'(WORD_W - 1) - BW'(step[SW-1:1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CHANNELS; i++) mem[i] <= '0;
    end else if (wr_valid && wr_ready && (int'(wr_addr) < CHANNELS)) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      hcnt  <= '0;
      step  <= '0;
      chan  <= '0;
    end else begin
      hcnt <= (state == S_IDLE || state == S_DONE || half_end) ? '0 : hcnt + 1'b1;
      unique case (state)
        S_IDLE: if (start) begin
          state <= S_SHIFT;
          step  <= '0;
          chan  <= '0;
        end
        S_SHIFT: if (half_end) begin
          if (step == SW'(WORD_LAST)) begin
            state <= S_GAP;
            step  <= '0;
          end else begin
            step <= step + 1'b1;
          end
        end
        S_GAP: if (half_end) begin
          if (chan == AW'(CHANNELS - 1)) begin
            state <= S_PRE;
          end else begin
            chan  <= chan + 1'b1;
            state <= S_SHIFT;
          end
        end
        S_PRE: if (half_end) begin
          state <= S_LATCH;
          step  <= '0;
        end
        S_LATCH: if (half_end) begin
          if (step == SW'(LATCH_LAST)) state <= S_POST;
          else step <= step + 1'b1;
        end
        S_POST:  if (half_end) state <= S_DONE;
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck   <= 1'b0;
      sin   <= 1'b0;
      trans <= 1'b0;
      done  <= 1'b0;
    end else begin
      sck   <= (state == S_SHIFT || state == S_LATCH) && step[0];
      trans <= (state == S_GAP || state == S_LATCH);
      sin   <= (state == S_SHIFT) ? mem[chan][bit_idx] : 1'b0;
      done  <= (state == S_DONE);
    end
  end

endmodule

// File: rtl/led_cmd_seq_chk.sv
module led_cmd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic wr_ready,
  input logic sck,
  input logic sin,
  input logic trans
);

  logic       sck_d;
  logic [3:0] latch_rises;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_d       <= 1'b0;
      latch_rises <= '0;
    end else begin
      sck_d <= sck;
      if (done) latch_rises <= '0;
      else if (sck && !sck_d && trans) latch_rises <= latch_rises + 1'b1;
    end
  end

  a_r3_sin_steady: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(sin));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sck && !trans));

  a_r5_three_latch: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (latch_rises == 4'd3));

endmodule

bind led_cmd_seq led_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .wr_ready(wr_ready),
  .sck(sck), .sin(sin), .trans(trans)
);

// File: tb/led_cmd_seq_test.sv
module led_cmd_seq_test;
  localparam int PERIOD = 10;
  localparam int CH = 4;
  localparam int WW = 16;
  localparam int H  = 2;
  localparam int FRAME_N = (2 * WW + 1) * H * CH + 9 * H + 2;
  localparam int NVEC = 3;
  localparam logic [15:0] VEC [0:NVEC*CH-1] = '{
    16'hFFFF, 16'h0000, 16'hA5C3, 16'h8001,
    16'h0000, 16'hFFFF, 16'h0001, 16'h8000,
    16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [1:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic start = 1'b0;
  logic busy, done, sck, sin, trans;

  int checks = 0;
  int fails = 0;

  always #(PERIOD/2) clk = ~clk;

  led_cmd_seq #(.CHANNELS(CH), .WORD_W(WW), .HALF_DIV(H)) uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .start(start), .busy(busy),
    .done(done), .sck(sck), .sin(sin), .trans(trans)
  );

  logic        p_sck = 1'b0;
  logic        p_sin = 1'b0;
  logic [15:0] acc = '0;
  int          nbits = 0;
  int          ncap = 0;
  logic [15:0] cap [0:63];
  int          latch_rises = 0;
  int          hi_len = 0;
  int          half_bad = 0;
  int          sin_bad = 0;
  int          done_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (sck && p_sck && sin != p_sin) sin_bad++;
      if (sck && !p_sck && sin != p_sin) sin_bad++;
      if (sck && !p_sck) begin
        if (!trans) begin
          acc = {acc[14:0], sin};
          nbits++;
          if (nbits == WW) begin
            if (ncap < 64) cap[ncap] = acc;
            ncap++;
            nbits = 0;
          end
        end else begin
          latch_rises++;
        end
      end
      if (sck) hi_len++;
      if (!sck && p_sck) begin
        if (hi_len != H) half_bad++;
        hi_len = 0;
      end
    end
    p_sck = sck;
    p_sin = sin;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_word(input int ch, input logic [15:0] val);
    @(negedge clk);
    wr_addr  = 2'(ch);
    wr_data  = val;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic run_frame(input int f, input bit disturb);
    int base_cap = ncap;
    int base_latch = latch_rises;
    int base_half = half_bad;
    int base_sin = sin_bad;
    int base_done = done_cnt;
    int n = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    check(busy == 1'b1, "R9 busy after start", busy, 1);
    while (!done && n < 5000) begin
      if (disturb && n == 50) begin
        start    = 1'b1;
        wr_valid = 1'b1;
        wr_addr  = 2'd0;
        wr_data  = 16'h0BAD;
        check(wr_ready == 1'b0, "R2 ready low in frame", wr_ready, 0);
      end else if (disturb && n == 51) begin
        start    = 1'b0;
        wr_valid = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    check(n == FRAME_N, "R7 frame length", n, FRAME_N);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", done, 0);
    check(!sck && !trans, "R5 latch ends low", {sck, trans}, 0);
    check(busy == 1'b0, "R9 idle after frame", busy, 0);
    if (disturb) repeat (400) @(negedge clk);
    check(ncap - base_cap == CH, "R4 word count", ncap - base_cap, CH);
    for (int c = 0; c < CH; c++) begin
      if (base_cap + c < 64)
        check(cap[base_cap + c] == VEC[f*CH + c], "R3 R4 word value",
              cap[base_cap + c], VEC[f*CH + c]);
    end
    check(latch_rises - base_latch == 3, "R5 latch pulses", latch_rises - base_latch, 3);
    check(half_bad == base_half, "R6 sck high width", half_bad - base_half, 0);
    check(sin_bad == base_sin, "R3 sin stable", sin_bad - base_sin, 0);
    check(done_cnt - base_done == 1, "R7 R8 single done", done_cnt - base_done, 1);
  endtask

  initial begin
    #(200000 * PERIOD);
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!sck && !sin && !trans, "R1 link idle", {sck, sin, trans}, 0);
    check(!done && !busy, "R1 status idle", {done, busy}, 0);
    check(wr_ready == 1'b1, "R1 ready", wr_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int f = 0; f < NVEC; f++) begin
      for (int c = 0; c < CH; c++) write_word(c, VEC[f*CH + c]);
      run_frame(f, 1'b0);
    end

    run_frame(NVEC - 1, 1'b1);
    check(!sck && !trans && !busy, "R8 quiet after ignored start",
          {sck, trans, busy}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule